// File: doc/BRIEF.md
# UART Command Frame Assembler

This block takes the byte stream from a UART receiver and turns it into register-access commands for a serial register writer further down the chain. Each command opens with a type byte. All ones (0xFF) means write and all zeros (0x00) means read. A write takes two more bytes, first the register address and then the value. A read takes one more byte, the address. When the last byte of a command arrives, the block presents a direction flag, a zero-extended address and a data value side by side, together with a start strobe that lasts one clock.

Several situations are absorbed rather than passed on. A type byte with any other value is thrown away, and the block keeps waiting for a valid one. A partial command is dropped when the line goes quiet for longer than a programmable number of clocks; the default corresponds to about 2 ms at 50 MHz. While the writer reports busy, one finished command waits in a single slot. Commands that finish while that slot is occupied are lost.

Top module: `uart_frame_asm`

## Requirements
- R1: While reset is asserted and right after it is released, `cmd_start`, `cmd_write`, `cmd_addr` and `cmd_data` are all zero.
- R2: The bytes 0xFF, A, D, each marked by `rx_valid`, produce one strobe with `cmd_write`=1, `cmd_addr`=A and `cmd_data`=D. If `wr_busy` is low, `cmd_start` is high in the third cycle after the cycle that carries the last byte.
- R3: The bytes 0x00, A produce one strobe with `cmd_write`=0, `cmd_addr`=A and `cmd_data`=0, with the same latency as R2.
- R4: A type byte other than 0x00 or 0xFF produces no strobe and does not start a command. The byte that follows it is again treated as a type byte.
- R5: `cmd_addr` carries the received address byte in bits 7:0. Bits 12:8 are always zero.
- R6: Once a partial command has started, the next byte continues it if it arrives no more than TIMEOUT_CYC cycles after the previous byte. If it arrives later, the partial command is discarded and that byte is decoded as a new type byte.
- R7: No strobe is given while `wr_busy` is high. A held command is strobed in the cycle after the first cycle in which `wr_busy` is low.
- R8: Only one finished command can wait for the writer. Commands that finish while it waits are dropped. A command that finishes in the same cycle the waiting one is issued is kept, and it is strobed in the next cycle.
- R9: Each accepted command gives exactly one single-cycle strobe. `cmd_write`, `cmd_addr` and `cmd_data` hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | One-cycle flag: `rx_byte` holds a freshly received byte |
| rx_byte | input | 8 | Received byte |
| wr_busy | input | 1 | Downstream writer is busy; a strobe is withheld while high |
| cmd_start | output | 1 | One-cycle command strobe |
| cmd_write | output | 1 | 1 = write command, 0 = read command |
| cmd_addr | output | 13 | Register address, zero-extended from the address byte |
| cmd_data | output | 8 | Value to write; zero for reads |

## Verification
Two events can fall in the same cycle. One is a new command completing. The other is the single waiting slot being issued when `wr_busy` drops. The bench provokes this by holding `wr_busy` high with one read waiting, then sending a second read whose completion lands exactly on the cycle in which `wr_busy` is released. The result counts as correct only if two strobes appear in consecutive cycles, in arrival order, with the right addresses. A drop of the second command, or a merge of the two, is a failure. The busy-held drop case and timeout gaps one cycle either side of the limit are checked alongside it.

// File: rtl/ufa_pkg.sv
`timescale 1ns/1ps
package ufa_pkg;
  // collection phase of the byte sequencer
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ufa_rst_sync.sv
`timescale 1ns/1ps
module ufa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ufa_gap_timer.sv
`timescale 1ns/1ps
module ufa_gap_timer #(
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,   // a partial command is open
  input  logic kick,    // a byte arrives this cycle
  output logic expire
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expire = armed && !kick && (cnt_q == LAST);

  always_comb begin
    if (!armed || kick || expire) cnt_d = '0;
    else                          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: the gap counter never runs past the limit
  a_r6_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R6: after an expiry the counter restarts from zero
  a_r6_expire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == '0));
endmodule

// File: rtl/ufa_byte_seq.sv
`timescale 1ns/1ps
module ufa_byte_seq
  import ufa_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              expire,
  output logic              armed,
  output logic              done,
  output logic              done_write,
  output logic [ADDR_W-1:0] done_addr,
  output logic [BYTE_W-1:0] done_data
);
  localparam logic [BYTE_W-1:0] TYPE_WR = '1;
  localparam logic [BYTE_W-1:0] TYPE_RD = '0;
  localparam int PAD_W = ADDR_W - BYTE_W;

  seq_state_e        state_q, state_d;
  logic              write_q, write_d;
  logic [BYTE_W-1:0] addr_q, addr_d;
  logic              done_d, dw_d;
  logic [ADDR_W-1:0] da_d;
  logic [BYTE_W-1:0] dd_d;
  logic              type_ok;

  assign type_ok = (rx_byte == TYPE_WR) || (rx_byte == TYPE_RD);
  assign armed   = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    write_d = write_q;
    addr_d  = addr_q;
    done_d  = 1'b0;
    dw_d    = done_write;
    da_d    = done_addr;
    dd_d    = done_data;
    case (state_q)
      ST_IDLE: begin
        if (rx_valid && type_ok) begin
          write_d = (rx_byte == TYPE_WR);
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (expire) begin
          state_d = ST_IDLE;
        end else if (rx_valid) begin
          addr_d = rx_byte;
          if (write_q) begin
            state_d = ST_DATA;
          end else begin
            done_d  = 1'b1;
            dw_d    = 1'b0;
            da_d    = {{PAD_W{1'b0}}, rx_byte};
            dd_d    = '0;
            state_d = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        if (expire) begin
          state_d = ST_IDLE;
        end else if (rx_valid) begin
          done_d  = 1'b1;
          dw_d    = 1'b1;
          da_d    = {{PAD_W{1'b0}}, addr_q};
          dd_d    = rx_byte;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      write_q    <= 1'b0;
      addr_q     <= '0;
      done       <= 1'b0;
      done_write <= 1'b0;
      done_addr  <= '0;
      done_data  <= '0;
    end else begin
      state_q <= state_d;
      write_q <= write_d;
      addr_q  <= addr_d;
      done    <= done_d;
      if (done_d) begin
        done_write <= dw_d;
        done_addr  <= da_d;
        done_data  <= dd_d;
      end
    end
  end

  // R2/R3: a completion is always triggered by a received byte
  a_r2_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rx_valid));
  // R4: an invalid type byte leaves the sequencer idle and silent
  a_r4_bad_type_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && rx_valid && !type_ok) |=> (state_q == ST_IDLE && !done));
  // R6: an expiry always returns to idle without a completion
  a_r6_expire_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (state_q == ST_IDLE && !done));
endmodule

// File: rtl/ufa_pend_slot.sv
`timescale 1ns/1ps
module ufa_pend_slot #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              busy,
  output logic              out_start,
  output logic              out_write,
  output logic [ADDR_W-1:0] out_addr,
  output logic [BYTE_W-1:0] out_data
);
  logic              vld_q, vld_d;
  logic              sw_q;
  logic [ADDR_W-1:0] sa_q;
  logic [BYTE_W-1:0] sd_q;
  logic              issue, take;

  assign issue = vld_q && !busy;
  assign take  = in_vld && (!vld_q || issue);

  always_comb begin
    if (take)       vld_d = 1'b1;
    else if (issue) vld_d = 1'b0;
    else            vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      sw_q      <= 1'b0;
      sa_q      <= '0;
      sd_q      <= '0;
      out_start <= 1'b0;
      out_write <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      vld_q     <= vld_d;
      out_start <= issue;
      if (take) begin
        sw_q <= in_write;
        sa_q <= in_addr;
        sd_q <= in_data;
      end
      if (issue) begin
        out_write <= sw_q;
        out_addr  <= sa_q;
        out_data  <= sd_q;
      end
    end
  end

  // R7: a strobe follows a cycle in which the writer was free
  a_r7_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> $past(!busy));
  // R8: a waiting command stays put while the writer is busy
  a_r8_slot_held: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && busy) |=> (vld_q && $stable(sa_q) && $stable(sw_q) && $stable(sd_q)));
  // R9: outputs only change together with a strobe
  a_r9_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_start |-> ($stable(out_addr) && $stable(out_data) && $stable(out_write)));
endmodule

// File: rtl/uart_frame_asm.sv
`timescale 1ns/1ps
module uart_frame_asm #(
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 13,
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              wr_busy,
  output logic              cmd_start,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BYTE_W-1:0] cmd_data
);
  logic              rst_i_n;
  logic              armed, expire;
  logic              done, done_write;
  logic [ADDR_W-1:0] done_addr;
  logic [BYTE_W-1:0] done_data;

  ufa_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  ufa_gap_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .armed  (armed),
    .kick   (rx_valid),
    .expire (expire)
  );

  ufa_byte_seq #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .expire     (expire),
    .armed      (armed),
    .done       (done),
    .done_write (done_write),
    .done_addr  (done_addr),
    .done_data  (done_data)
  );

  ufa_pend_slot #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .in_vld    (done),
    .in_write  (done_write),
    .in_addr   (done_addr),
    .in_data   (done_data),
    .busy      (wr_busy),
    .out_start (cmd_start),
    .out_write (cmd_write),
    .out_addr  (cmd_addr),
    .out_data  (cmd_data)
  );

  // R3: a read never carries a data value
  a_r3_read_data_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_start && !cmd_write) |-> (cmd_data == '0));
  // R5: upper address bits stay clear
  a_r5_addr_upper_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    cmd_addr[ADDR_W-1:BYTE_W] == '0);
endmodule

// File: tb/uart_frame_asm_test.sv
`timescale 1ns/1ps
module uart_frame_asm_test;
  localparam int T = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        wr_busy = 1'b0;
  logic        cmd_start, cmd_write;
  logic [12:0] cmd_addr;
  logic [7:0]  cmd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int obs_cnt = 0;
  bit finished = 0;
  logic        obs_w [64];
  logic [12:0] obs_a [64];
  logic [7:0]  obs_d [64];
  int          obs_c [64];

  uart_frame_asm #(.TIMEOUT_CYC(T)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .wr_busy(wr_busy), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cmd_start) begin
      obs_w[obs_cnt % 64] = cmd_write;
      obs_a[obs_cnt % 64] = cmd_addr;
      obs_d[obs_cnt % 64] = cmd_data;
      obs_c[obs_cnt % 64] = cyc;
      obs_cnt = obs_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output int at);
    rx_valid = 1'b1;
    rx_byte  = b;
    at = cyc;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = 8'hC3;
  endtask

  task automatic exp_cmd(input string req, input int idx, input logic w,
                         input logic [12:0] a, input logic [7:0] d, input int c);
    chk(obs_cnt > idx, req, "strobe present", obs_cnt, idx + 1);
    if (obs_cnt > idx) begin
      chk(obs_w[idx % 64] == w, req, "write flag", obs_w[idx % 64], w);
      chk(obs_a[idx % 64] == a, req, "address", obs_a[idx % 64], a);
      chk(obs_d[idx % 64] == d, req, "data", obs_d[idx % 64], d);
      if (c >= 0) chk(obs_c[idx % 64] == c, req, "strobe cycle", obs_c[idx % 64], c);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, t0, t1, t2;
    idle(3);
    // R1: reset values
    chk(cmd_start == 0 && cmd_write == 0 && cmd_addr == 0 && cmd_data == 0,
        "R1", "outputs in reset", {cmd_start, cmd_write, cmd_addr, cmd_data}, 0);
    rst_n = 1'b1;
    idle(4);
    chk(cmd_start == 0 && cmd_write == 0 && cmd_addr == 0 && cmd_data == 0,
        "R1", "outputs after reset", {cmd_start, cmd_write, cmd_addr, cmd_data}, 0);

    // R4 / R3 / R2: sweep every type byte value
    for (int t = 0; t < 256; t++) begin
      base = obs_cnt;
      if (t == 8'hFF) begin
        send_byte(8'hFF, t0); send_byte(8'hA5, t1); send_byte(8'h3C, t2);
        idle(6);
        exp_cmd("R2", base, 1'b1, 13'h0A5, 8'h3C, t2 + 3);
      end else if (t == 0) begin
        send_byte(8'h00, t0); send_byte(8'h81, t1);
        idle(6);
        exp_cmd("R3", base, 1'b0, 13'h081, 8'h00, t1 + 3);
      end else begin
        send_byte(8'(t), t0); send_byte(8'h00, t1); send_byte(8'(t), t2);
        idle(6);
        exp_cmd("R4", base, 1'b0, 13'(t), 8'h00, t2 + 3);
      end
      chk(obs_cnt == base + 1, "R4", "strobe count", obs_cnt - base, 1);
    end

    // R2 / R5: sweep every address with a write
    for (int a = 0; a < 256; a++) begin
      base = obs_cnt;
      send_byte(8'hFF, t0); send_byte(8'(a), t1); send_byte(8'(a * 7 + 3), t2);
      idle(5);
      exp_cmd("R2", base, 1'b1, 13'(a), 8'(a * 7 + 3), t2 + 3);
      chk(cmd_addr[12:8] == 0, "R5", "upper address bits", cmd_addr[12:8], 0);
      chk(obs_cnt == base + 1, "R9", "one strobe per command", obs_cnt - base, 1);
    end

    // R3 / R5: reads across addresses
    for (int a = 0; a < 256; a += 17) begin
      base = obs_cnt;
      send_byte(8'h00, t0); send_byte(8'(a), t1);
      idle(5);
      exp_cmd("R3", base, 1'b0, 13'(a), 8'h00, t1 + 3);
    end

    // R9: outputs hold after the strobe
    idle(10);
    chk(cmd_addr == 13'(255 / 17 * 17) && cmd_write == 0 && cmd_data == 0,
        "R9", "outputs hold", cmd_addr, 13'(255 / 17 * 17));

    // R6: gaps of exactly T cycles are tolerated
    base = obs_cnt;
    send_byte(8'hFF, t0); idle(T - 1); send_byte(8'h12, t1); idle(T - 1);
    send_byte(8'h9E, t2); idle(6);
    exp_cmd("R6", base, 1'b1, 13'h012, 8'h9E, t2 + 3);
    chk(obs_cnt == base + 1, "R6", "strobe count at limit", obs_cnt - base, 1);

    // R6: gap of T+1 after type byte drops the partial command
    base = obs_cnt;
    send_byte(8'hFF, t0); idle(T); send_byte(8'h00, t1); send_byte(8'h34, t2);
    idle(6);
    exp_cmd("R6", base, 1'b0, 13'h034, 8'h00, t2 + 3);
    chk(obs_cnt == base + 1, "R6", "strobe count past limit", obs_cnt - base, 1);

    // R6: gap of T+1 after the address of a write
    base = obs_cnt;
    send_byte(8'hFF, t0); send_byte(8'h11, t1); idle(T);
    send_byte(8'h00, t1); send_byte(8'h22, t2); idle(6);
    exp_cmd("R6", base, 1'b0, 13'h022, 8'h00, t2 + 3);
    chk(obs_cnt == base + 1, "R6", "write dropped", obs_cnt - base, 1);

    // R6 / R4: late byte decoded as an invalid type byte
    base = obs_cnt;
    send_byte(8'h00, t0); idle(T); send_byte(8'h55, t1);
    send_byte(8'h00, t1); send_byte(8'h66, t2); idle(6);
    exp_cmd("R6", base, 1'b0, 13'h066, 8'h00, t2 + 3);
    chk(obs_cnt == base + 1, "R6", "late byte ignored", obs_cnt - base, 1);

    // R7 / R8: busy holds one command, later ones dropped
    base = obs_cnt;
    wr_busy = 1'b1;
    send_byte(8'h00, t0); send_byte(8'h40, t1);
    send_byte(8'hFF, t0); send_byte(8'h41, t1); send_byte(8'h99, t2);
    idle(20);
    chk(obs_cnt == base, "R7", "no strobe while busy", obs_cnt - base, 0);
    t0 = cyc;
    wr_busy = 1'b0;
    idle(10);
    exp_cmd("R7", base, 1'b0, 13'h040, 8'h00, t0 + 1);
    chk(obs_cnt == base + 1, "R8", "second command dropped", obs_cnt - base, 1);

    // R8: completion in the same cycle the slot is issued
    base = obs_cnt;
    wr_busy = 1'b1;
    send_byte(8'h00, t0); send_byte(8'h50, t1);
    idle(3);
    send_byte(8'h00, t0); send_byte(8'h51, t1);
    wr_busy = 1'b0;
    idle(8);
    exp_cmd("R8", base, 1'b0, 13'h050, 8'h00, t1 + 2);
    exp_cmd("R8", base + 1, 1'b0, 13'h051, 8'h00, t1 + 3);
    chk(obs_cnt == base + 2, "R8", "both commands kept", obs_cnt - base, 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule